// File: doc/BRIEF.md
# Pipeline Register File with Same-Cycle Write Bypass

This block holds the architectural integer registers of a five-stage pipeline: thirty-two words of thirty-two bits, two read ports and one write port. The decode stage presents two register numbers and receives their contents combinationally. In the same clock, the write-back stage presents a register number, a data word and an enable, and the word is stored on the rising edge.

A write-back and a decode read of the same register often fall in the same cycle. Each read port compares its own address with the write address. When the write is enabled and the addresses match, that port returns the incoming write data instead of the stored value. The decode stage therefore sees the new value without waiting a cycle. Register 0 is hard-wired to zero: it ignores writes and never takes part in the bypass. All other registers clear to zero on reset.

Top module: `regfile_bypass`

## Requirements
- R1: After reset, every register reads as zero on both read ports.
- R2: When wr_en_i is 1 and wr_addr_i is not 0, wr_data_i is stored in register wr_addr_i at the rising clock edge. It is readable from either port afterwards.
- R3: When wr_en_i is 0, no register changes at the clock edge.
- R4: Register 0 always reads as zero, and writes addressed to it are discarded.
- R5: When wr_en_i is 1 and wr_addr_i equals rd_addr_a_i (not 0), rd_data_a_o shows wr_data_i in the same cycle, before the clock edge.
- R6: When wr_en_i is 1 and wr_addr_i equals rd_addr_b_i (not 0), rd_data_b_o shows wr_data_i in the same cycle.
- R7: Both read ports may bypass at once when both addresses match the write address.
- R8: A write enabled to address 0 is not bypassed: a port reading address 0 still shows zero.
- R9: A matching address with wr_en_i at 0 does not bypass: the port shows the stored value.
- R10: Read data follows a change of read address combinationally, with no clock edge.
- R11: The two read ports are independent: different addresses return their own registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge stores writes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_a_i | input | 5 | Register number for read port A |
| rd_data_a_o | output | 32 | Data of read port A |
| rd_addr_b_i | input | 5 | Register number for read port B |
| rd_data_b_o | output | 32 | Data of read port B |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Register number to write |
| wr_data_i | input | 32 | Data to write |

## Verification
The decode read and the write-back store of the same register land in one cycle. This is the case the bypass exists for. The bench provokes it by driving a matching read and write address after the falling edge. It samples the read data before the next rising edge, so only the bypass can supply the new word. It then reads again after the edge to confirm the array also took it. Address 0 and a disabled write are driven with matching addresses to show that the bypass is held off when it must be.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;

  // bypass selects write data only for an enabled, matching, non-zero address
  function automatic logic bypass_hit(input logic wr_en, input logic [31:0] wr_addr,
                                      input logic [31:0] rd_addr);
    return wr_en && (wr_addr == rd_addr) && (rd_addr != 32'd0);
  endfunction
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = rf_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rf_pkg::DEF_DATA_W,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [AW-1:0]                    wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  assign regs_o[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_en_i && (wr_addr_i == AW'(g))) q <= wr_data_i;
    end
    assign regs_o[g] = q;
  end

  // R2: enabled write to non-zero entry lands
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=> regs_o[$past(wr_addr_i)] == $past(wr_data_i));

  // R3: no change without enable
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = rf_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rf_pkg::DEF_DATA_W,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [AW-1:0]                   rd_addr_i,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [DATA_W-1:0]               rd_data_o
);

  logic hit;
  assign hit = rf_pkg::bypass_hit(wr_en_i, 32'(wr_addr_i), 32'(rd_addr_i));

  always_comb begin
    if (hit) rd_data_o = wr_data_i;
    else     rd_data_o = regs_i[rd_addr_i];
  end

endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int unsigned NUM_REGS = rf_pkg::DEF_NUM_REGS,
  parameter int unsigned DATA_W   = rf_pkg::DEF_DATA_W,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [AW-1:0]     rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);

  localparam int unsigned NUM_RD = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][AW-1:0]       rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  assign rd_addr[0]  = rd_addr_a_i;
  assign rd_addr[1]  = rd_addr_b_i;
  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_storage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .regs_i    (regs),
      .rd_addr_i (rd_addr[p]),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end

  // R5 / R6: same-cycle bypass at the ports
  a_r5_bypass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_a_i && rd_addr_a_i != '0) |-> rd_data_a_o == wr_data_i);
  a_r6_bypass_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_b_i && rd_addr_b_i != '0) |-> rd_data_b_o == wr_data_i);

  // R4 / R8: register 0 reads zero, bypass or not
  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> rd_data_a_o == '0);
  a_r8_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> rd_data_b_o == '0);

  // R10: port A follows a stable register through an address-free edge
  a_r10_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_addr_a_i) && !$past(wr_en_i)) |-> $stable(rd_data_a_o) || wr_en_i);

endmodule

// File: tb/regfile_bypass_tb.sv
module regfile_bypass_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_addr_a_i = '0, rd_addr_b_i = '0, wr_addr_i = '0;
  logic [31:0] rd_data_a_o, rd_data_b_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #10 clk_i = ~clk_i;

  regfile_bypass dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
    .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i)
  );

  function automatic logic [31:0] pat(int i);
    return 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 20);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) begin
      rd_addr_a_i = 5'(i); rd_addr_b_i = 5'(31 - i); #1;
      chk("R1 port A", rd_data_a_o, 32'h0);
      chk("R1 port B", rd_data_b_o, 32'h0);
    end
  endtask

  task automatic t_fill;
    for (int i = 1; i < 32; i++) wr(5'(i), pat(i));
    for (int i = 0; i < 32; i++) begin
      rd_addr_a_i = 5'(i); rd_addr_b_i = 5'(31 - i); #1;
      chk("R2/R11 port A", rd_data_a_o, model[i]);
      chk("R2/R11 port B", rd_data_b_o, model[31 - i]);
    end
  endtask

  task automatic t_no_enable;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 5'd5; wr_data_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    rd_addr_a_i = 5'd5; #1;
    chk("R3 disabled write", rd_data_a_o, model[5]);
  endtask

  task automatic t_reg0;
    wr(5'd0, 32'hFFFF_FFFF);
    rd_addr_a_i = 5'd0; rd_addr_b_i = 5'd0; #1;
    chk("R4 port A", rd_data_a_o, 32'h0);
    chk("R4 port B", rd_data_b_o, 32'h0);
  endtask

  task automatic t_bypass;
    // port A matches, B reads another register
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd7; wr_data_i = 32'h1234_5678;
    rd_addr_a_i = 5'd7; rd_addr_b_i = 5'd8; #2;
    chk("R5 bypass A", rd_data_a_o, 32'h1234_5678);
    chk("R11 B unaffected", rd_data_b_o, model[8]);
    @(negedge clk_i);
    wr_en_i = 1'b0; model[7] = 32'h1234_5678; #1;
    chk("R2 stored after bypass", rd_data_a_o, 32'h1234_5678);
    // port B matches
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd12; wr_data_i = 32'h0BAD_F00D;
    rd_addr_a_i = 5'd13; rd_addr_b_i = 5'd12; #2;
    chk("R6 bypass B", rd_data_b_o, 32'h0BAD_F00D);
    chk("R6 A unaffected", rd_data_a_o, model[13]);
    @(negedge clk_i);
    wr_en_i = 1'b0; model[12] = 32'h0BAD_F00D;
    // both match
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd9; wr_data_i = 32'hCAFE_0009;
    rd_addr_a_i = 5'd9; rd_addr_b_i = 5'd9; #2;
    chk("R7 both A", rd_data_a_o, 32'hCAFE_0009);
    chk("R7 both B", rd_data_b_o, 32'hCAFE_0009);
    @(negedge clk_i);
    wr_en_i = 1'b0; model[9] = 32'hCAFE_0009;
  endtask

  task automatic t_suppress;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'd0; wr_data_i = 32'h5555_AAAA;
    rd_addr_a_i = 5'd0; rd_addr_b_i = 5'd0; #2;
    chk("R8 no bypass A", rd_data_a_o, 32'h0);
    chk("R8 no bypass B", rd_data_b_o, 32'h0);
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 5'd10; wr_data_i = 32'h7777_7777;
    rd_addr_a_i = 5'd10; rd_addr_b_i = 5'd10; #2;
    chk("R9 disabled match A", rd_data_a_o, model[10]);
    chk("R9 disabled match B", rd_data_b_o, model[10]);
    @(negedge clk_i); #1;
    chk("R9 not stored", rd_data_a_o, model[10]);
  endtask

  task automatic t_comb;
    @(negedge clk_i);
    rd_addr_a_i = 5'd3; #1;
    chk("R10 first addr", rd_data_a_o, model[3]);
    rd_addr_a_i = 5'd30; #1;
    chk("R10 second addr", rd_data_a_o, model[30]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_fill();
    t_no_enable();
    t_reg0();
    t_bypass();
    t_suppress();
    t_comb();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule